// File: doc/BRIEF.md
# CAN Sleep and Wake-Up Controller

This block owns the low-power state of a CAN protocol controller. Software requests sleep with a single-cycle write strobe, and it ends sleep with a second strobe. Sleep also ends when the sampled receive line shows a dominant level at a bit-time strobe. Every wake-up is an event. If the wake-up interrupt enable is high in that cycle, the event latches a sticky flag, and a read-clear strobe removes the flag.

The block watches the receive stream at all times with a counter of consecutive recessive bits. After a wake-up caused by the bus, the receive-enable qualifier stays low until the counter has seen the bus free. This keeps the frame decoder away from a message that was already under way when the node woke. A sleep request made while an interrupt is pending, or while the bus is busy, is not honoured. It counts as an immediate wake-up instead.

Top module: `can_sleep_ctrl`

## Requirements
- R1: Synchronous reset leaves the block awake (`asleep_o`=0) with `wake_flag_o`=0 and `rx_enable_o`=1.
- R2: A `sleep_set_i` pulse while awake, with `irq_pend_i`=0 and `bus_busy_i`=0, raises `asleep_o` at the next edge. `rx_enable_o` is 0 while asleep.
- R3: A `sleep_set_i` pulse while awake, with `irq_pend_i`=1 or `bus_busy_i`=1, leaves `asleep_o` at 0 and counts as a wake-up event.
- R4: While asleep, a dominant sample clears `asleep_o` at the next edge. A dominant sample is `bit_tick_i`=1 with `rx_bit_i`=0, where 0 is dominant and 1 is recessive. `rx_bit_i`=0 without a tick has no effect. If a dominant sample and `sleep_clr_i` arrive together, the wake counts as bus-caused.
- R5: While asleep, a `sleep_clr_i` pulse clears `asleep_o` at the next edge. While awake, `sleep_clr_i` has no effect.
- R6: A wake-up event sets `wake_flag_o` at the next edge only when `wake_irq_en_i`=1. The flag holds until a `flag_rd_i` pulse. A set in the same cycle as a read-clear wins.
- R7: After a bus-caused wake, `rx_enable_o` stays 0 until IDLE_BITS (default 11) consecutive recessive samples have been taken. It rises at the edge of the last of those samples. Any dominant sample restarts the count.
- R8: After a software wake with no bus hold-off pending, `rx_enable_o` returns to 1 at the same edge at which `asleep_o` falls.
- R9: A `sleep_set_i` pulse while asleep has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_set_i | input | 1 | Software write strobe requesting sleep |
| sleep_clr_i | input | 1 | Software write strobe clearing sleep |
| rx_bit_i | input | 1 | Sampled receive level, 0 dominant |
| bit_tick_i | input | 1 | Bit-time sample strobe |
| irq_pend_i | input | 1 | An interrupt is pending |
| bus_busy_i | input | 1 | Bus is active |
| wake_irq_en_i | input | 1 | Wake-up interrupt enable |
| flag_rd_i | input | 1 | Read-clear strobe for the wake flag |
| asleep_o | output | 1 | Sleeping status |
| wake_flag_o | output | 1 | Sticky wake-up interrupt flag |
| rx_enable_o | output | 1 | Frame reception permitted |

## Verification
Every output is registered once. The effect of an input pattern, including a bus-free count completed by a tick, therefore shows exactly one edge after it is applied. The bench drives inputs after a falling edge and advances its reference model by one step for that pattern. It then compares all three outputs at the following falling edge, which is one rising edge later. Directed sequences pin down the IDLE_BITS boundary (one sample short and exactly on it), the restart of the count on a dominant sample, and same-cycle collisions. Random traffic with a fixed seed covers the remaining combinations.

// File: rtl/can_sleep_ctrl.sv
module can_sleep_ctrl #(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_set_i,
  input  logic sleep_clr_i,
  input  logic rx_bit_i,
  input  logic bit_tick_i,
  input  logic irq_pend_i,
  input  logic bus_busy_i,
  input  logic wake_irq_en_i,
  input  logic flag_rd_i,
  output logic asleep_o,
  output logic wake_flag_o,
  output logic rx_enable_o
);
  localparam int CW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] FREE = CW'(IDLE_BITS);

  logic [CW-1:0] idle_cnt, idle_nxt;
  logic asleep_q, hold_q, flag_q;
  logic dom, bus_wake, sw_wake, early_wake, wake_evt, go_sleep;

  assign dom        = bit_tick_i & ~rx_bit_i;
  assign bus_wake   = asleep_q & dom;
  assign sw_wake    = asleep_q & ~dom & sleep_clr_i;
  assign early_wake = ~asleep_q & sleep_set_i & (irq_pend_i | bus_busy_i);
  assign go_sleep   = ~asleep_q & sleep_set_i & ~irq_pend_i & ~bus_busy_i;
  assign wake_evt   = bus_wake | sw_wake | early_wake;

  always_comb begin
    idle_nxt = idle_cnt;
    if (bit_tick_i) begin
      if (!rx_bit_i)             idle_nxt = '0;
      else if (idle_cnt != FREE) idle_nxt = idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= '0;
      asleep_q <= 1'b0;
      hold_q   <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      idle_cnt <= idle_nxt;
      if (go_sleep) asleep_q <= 1'b1;
      else if (bus_wake | sw_wake) asleep_q <= 1'b0;
      if (bus_wake) hold_q <= 1'b1;
      else if (idle_nxt == FREE) hold_q <= 1'b0;
      if (wake_evt && wake_irq_en_i) flag_q <= 1'b1;
      else if (flag_rd_i) flag_q <= 1'b0;
    end
  end

  assign asleep_o    = asleep_q;
  assign wake_flag_o = flag_q;
  assign rx_enable_o = ~asleep_q & ~hold_q;

  // R4 R5
  wake_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(asleep_q) |-> $past(dom | sleep_clr_i));
  // R2 R3
  sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(asleep_q) |-> $past(sleep_set_i & ~irq_pend_i & ~bus_busy_i));
  // R6
  flag_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(wake_irq_en_i));
  // R7
  hold_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_q) |-> $past(dom) && !asleep_q);
  // R7
  hold_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_q) |-> idle_cnt == FREE);
  // R2
  rx_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    asleep_q |-> !rx_enable_o);
  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    idle_cnt <= FREE);
endmodule

// File: tb/sim_can_sleep_ctrl.sv
module sim_can_sleep_ctrl;
  localparam int PERIOD = 10;
  localparam int IDLE = 11;

  logic clk = 1'b0, rst = 1'b1;
  logic set_s = 0, clr_s = 0, rx = 1, tick = 0, pend = 0, busy = 0, en = 0, rd = 0;
  logic asleep, flag, rxen;
  int checks = 0, fails = 0;
  bit done = 0;

  logic m_asleep = 0, m_flag = 0, m_hold = 0;
  int   m_cnt = 0;

  always #(PERIOD/2) clk = ~clk;

  can_sleep_ctrl #(.IDLE_BITS(IDLE)) u0 (
    .clk(clk), .rst(rst), .sleep_set_i(set_s), .sleep_clr_i(clr_s),
    .rx_bit_i(rx), .bit_tick_i(tick), .irq_pend_i(pend), .bus_busy_i(busy),
    .wake_irq_en_i(en), .flag_rd_i(rd),
    .asleep_o(asleep), .wake_flag_o(flag), .rx_enable_o(rxen));

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic m_rxen();
    return !m_asleep && !m_hold;
  endfunction

  task automatic model_step();
    logic dom, wake;
    int cn;
    if (rst) begin
      m_asleep = 0; m_flag = 0; m_hold = 0; m_cnt = 0;
      return;
    end
    dom = tick && !rx;
    cn = !tick ? m_cnt : (!rx ? 0 : (m_cnt == IDLE ? IDLE : m_cnt + 1));
    wake = 0;
    if (m_asleep) begin
      if (dom) begin m_asleep = 0; m_hold = 1; wake = 1; end
      else if (clr_s) begin m_asleep = 0; wake = 1; end
    end else if (set_s) begin
      if (pend || busy) wake = 1; else m_asleep = 1;
    end
    if (m_hold && !(m_asleep == 0 && dom && wake) && cn == IDLE) m_hold = 0;
    if (wake && en) m_flag = 1; else if (rd) m_flag = 0;
    m_cnt = cn;
  endtask

  task automatic step();
    model_step();
    @(negedge clk);
    chk("R2/R4/R5/R9 asleep", asleep, m_asleep);
    chk("R3/R6 wake_flag", flag, m_flag);
    chk("R7/R8 rx_enable", rxen, m_rxen());
  endtask

  task automatic idle_in();
    set_s = 0; clr_s = 0; rx = 1; tick = 0; rd = 0; pend = 0; busy = 0;
  endtask

  task automatic ticks(int n, logic lvl);
    for (int i = 0; i < n; i++) begin idle_in(); tick = 1; rx = lvl; step(); end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); step(); step();
    rst = 0;
    // R1
    chk("R1 asleep", asleep, 0); chk("R1 flag", flag, 0); chk("R1 rx_enable", rxen, 1);

    // R2
    idle_in(); en = 1; set_s = 1; step();
    chk("R2 asleep", asleep, 1); chk("R2 rx_enable", rxen, 0);
    // R9
    idle_in(); set_s = 1; step();
    chk("R9 asleep", asleep, 1); chk("R9 flag", flag, 0);
    // R4 no tick
    idle_in(); rx = 0; step();
    chk("R4 no tick", asleep, 1);
    // R4 dominant with clear: bus wake
    idle_in(); tick = 1; rx = 0; clr_s = 1; step();
    chk("R4 wake", asleep, 0); chk("R6 flag set", flag, 1); chk("R7 held", rxen, 0);
    ticks(IDLE - 1, 1);
    chk("R7 one short", rxen, 0);
    ticks(1, 0);
    ticks(IDLE - 1, 1);
    chk("R7 restart", rxen, 0);
    ticks(1, 1);
    chk("R7 released", rxen, 1);
    // R6 read-clear
    idle_in(); rd = 1; step();
    chk("R6 cleared", flag, 0);
    // R5 R8 software wake, enable off
    en = 0; idle_in(); set_s = 1; step();
    idle_in(); clr_s = 1; step();
    chk("R5 wake", asleep, 0); chk("R8 rx_enable", rxen, 1); chk("R6 no flag", flag, 0);
    idle_in(); clr_s = 1; step();
    chk("R5 clr awake", asleep, 0);
    // R3 with set+read same cycle
    en = 1; idle_in(); set_s = 1; pend = 1; rd = 1; step();
    chk("R3 stays awake", asleep, 0); chk("R3/R6 flag", flag, 1);
    idle_in(); set_s = 1; busy = 1; step();
    chk("R3 busy", asleep, 0);

    for (int c = 0; c < 6000; c++) begin
      idle_in();
      tick  = ($urandom_range(0, 3) == 0);
      rx    = ($urandom_range(0, 9) != 0);
      set_s = ($urandom_range(0, 19) == 0);
      clr_s = ($urandom_range(0, 29) == 0);
      pend  = ($urandom_range(0, 7) == 0);
      busy  = ($urandom_range(0, 7) == 0);
      en    = $urandom_range(0, 1);
      rd    = ($urandom_range(0, 14) == 0);
      step();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule